// File: doc/BRIEF.md
# Byte-Parity Error Reporter

This unit watches every read returned by a shared memory and checks one parity bit per data byte. It checks both reads that the local processor issues and reads that arrive from the external system bus, where the board acts as a slave. On a mismatch the unit reports the fault in the way that suits the side that started the access.

An external master gets a bus-error response in place of the normal acknowledge. A local read still ends with a normal synchronous termination, and an interrupt request is raised at a priority level that software programs. In both cases the address of the first failing read is held in a register for software. That register stays held until software clears a write-one-to-clear status bit. The memory array and the interrupt controller lie outside the block.

Top module: `pe_report_unit`

## Requirements
- R1: Even parity is used. Byte i is `rd_data[8i+7:8i]` and its parity bit is `rd_par[i]`. The byte is in error when the XOR of its eight data bits and its parity bit is 1.
- R2: Only bytes whose `rd_be[i]` is 1 are checked. A mismatch in a byte with `rd_be[i]` = 0 has no effect on any output.
- R3: One cycle after a cycle with `rd_valid` = 1, exactly one of `term_ok` and `bus_err` is high for that one cycle. `bus_err` is chosen only when `rd_ext` = 1 and an enabled byte is in error. Without a read, both stay low.
- R4: A local read (`rd_ext` = 0) that has a parity error still gets `term_ok`.
- R5: A local read with a parity error sets an interrupt-pending state. An external error does not set it. `irq_req` is high while that state is set and the programmed level is non-zero. The state holds until software clears it.
- R6: The 3-bit level is loaded from `cfg_lvl` when `cfg_lvl_we` = 1. `irq_lvl` shows the level while `irq_req` is high and shows 0 otherwise. A level of 0 keeps `irq_req` low.
- R7: The first parity error captures `rd_addr` into `err_addr` and sets `err_valid`. Both are visible in the cycle after the read.
- R8: While `err_valid` is set, later errors leave `err_addr` unchanged and set the sticky flag `err_ovf`.
- R9: A cycle with `sts_clr` = 1 clears `err_valid`, `err_ovf` and the interrupt-pending state. If a parity error arrives in the same cycle, it is captured as a new first error and `err_ovf` stays 0.
- R10: After a synchronous active-low reset, all outputs are 0 and the level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | A read returns data this cycle |
| rd_ext | input | 1 | 1 = external-bus slave read, 0 = local read |
| rd_addr | input | ADDR_W | Address of the read |
| rd_be | input | DATA_W/8 | Byte enables of the read |
| rd_data | input | DATA_W | Read data |
| rd_par | input | DATA_W/8 | Stored parity bits, one per byte |
| cfg_lvl_we | input | 1 | Load the interrupt level |
| cfg_lvl | input | 3 | New interrupt level |
| sts_clr | input | 1 | Write-one-to-clear of the error status |
| term_ok | output | 1 | Normal termination of the read |
| bus_err | output | 1 | Bus-error response to the external master |
| irq_req | output | 1 | Interrupt request |
| irq_lvl | output | 3 | Level of the pending request, 0 when idle |
| err_valid | output | 1 | An error address is held |
| err_ovf | output | 1 | Further errors arrived while the address was held |
| err_addr | output | ADDR_W | Address of the first failing read |

## Verification
The bench drives a mismatch in a disabled byte. A design that ignored the byte enables would capture that address and would answer an external master with a bus error. It also sends an external error while a local error is already held. This catches a design that overwrites the held address or raises an interrupt for the external error.

Clearing the status in the same cycle as a new error is tested directly. A design that lets the clear win would lose that error, and one that counts the error as an overflow would set `err_ovf` falsely. Level 0 with a pending error, followed by a non-zero level, shows whether the request is gated by the level or latched at error time.

// File: rtl/pe_pkg.sv
// Package: shared widths and the even-parity helper for the parity error reporter.
// Assumes: one parity bit per 8-bit byte.
package pe_pkg;
    localparam int LVL_W = 3;

    // Returns 1 when a byte and its parity bit do not form even parity.
    function automatic logic byte_bad(input logic [7:0] b, input logic p);
        return (^b) ^ p;
    endfunction
endpackage

// File: rtl/pe_byte_check.sv
// Module: pe_byte_check
// Checks even parity per byte and masks the result with the byte enables.
// Combinational. Assumes DATA_W is a multiple of 8.
module pe_byte_check #(
    parameter int DATA_W = 32,
    localparam int NB = DATA_W / 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [NB-1:0]     par,
    input  logic [NB-1:0]     be,
    output logic [NB-1:0]     bad,
    output logic              any_bad
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        // Flags one enabled byte whose parity does not match.
        always_comb bad[i] = be[i] & pe_pkg::byte_bad(data[8*i +: 8], par[i]);
    end

    // Combines the per-byte flags into one error flag.
    always_comb any_bad = |bad;
endmodule

// File: rtl/pe_resp.sv
// Module: pe_resp
// Registers the termination of each read. A normal termination is given unless
// an external slave read failed parity, which gets a bus error instead.
// Assumes at most one read per cycle.
module pe_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_valid,
    input  logic rd_ext,
    input  logic par_err,
    output logic term_ok,
    output logic bus_err
);
    // Chooses the response one cycle after the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_ok <= 1'b0;
            bus_err <= 1'b0;
        end else begin
            term_ok <= rd_valid & ~(rd_ext & par_err);
            bus_err <= rd_valid & rd_ext & par_err;
        end
    end

    AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({term_ok, bus_err}));                                 // R3
    AST_RESP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (term_ok || bus_err));                            // R3
    AST_BERR_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(rd_valid && rd_ext));                        // R3
    AST_LOCAL_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ext) |=> term_ok);                            // R4
endmodule

// File: rtl/pe_capture.sv
// Module: pe_capture
// Holds the address of the first parity error, a sticky overflow flag and the
// local-interrupt pending state. A status clear in the same cycle as a new
// error leaves that error captured as a fresh first error.
module pe_capture #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic              rd_ext,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              par_err,
    input  logic              sts_clr,
    output logic              err_valid,
    output logic              err_ovf,
    output logic [ADDR_W-1:0] err_addr,
    output logic              loc_pend
);
    logic hit;

    // Marks a read that failed parity.
    always_comb hit = rd_valid & par_err;

    // Updates the captured address, the status flags and the pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_ovf   <= 1'b0;
            err_addr  <= '0;
            loc_pend  <= 1'b0;
        end else if (sts_clr) begin
            err_valid <= hit;
            err_ovf   <= 1'b0;
            loc_pend  <= hit & ~rd_ext;
            if (hit) err_addr <= rd_addr;
        end else if (hit) begin
            if (!err_valid) begin
                err_valid <= 1'b1;
                err_addr  <= rd_addr;
            end else begin
                err_ovf <= 1'b1;
            end
            if (!rd_ext) loc_pend <= 1'b1;
        end
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_valid) && !$past(sts_clr)) |-> $stable(err_addr));  // R8
    AST_OVF_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |-> err_valid);                                        // R8
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !rd_valid) |=> (!err_valid && !err_ovf && !loc_pend)); // R9
endmodule

// File: rtl/pe_irq.sv
// Module: pe_irq
// Holds the software-set interrupt level and drives the request from the
// pending state. A level of 0 masks the request.
module pe_irq (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_lvl_we,
    input  logic [pe_pkg::LVL_W-1:0] cfg_lvl,
    input  logic                    loc_pend,
    output logic                    irq_req,
    output logic [pe_pkg::LVL_W-1:0] irq_lvl
);
    logic [pe_pkg::LVL_W-1:0] lvl_q;

    // Stores the programmed interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n)          lvl_q <= '0;
        else if (cfg_lvl_we) lvl_q <= cfg_lvl;
    end

    // Raises the request at the stored level while an error is pending.
    always_comb begin
        irq_req = loc_pend & (lvl_q != '0);
        irq_lvl = irq_req ? lvl_q : '0;
    end

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> loc_pend);                                         // R5
    AST_IDLE_LVL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_lvl == '0));                                 // R6
endmodule

// File: rtl/pe_report_unit.sv
// Module: pe_report_unit (top)
// Checks byte parity on every read and reports errors by the origin of the
// access: a bus error for external slave reads, and a normal termination plus
// an interrupt for local reads. Captures the first failing address.
// Assumes one read per cycle and even parity, one bit per byte.
module pe_report_unit #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int NB = DATA_W / 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_valid,
    input  logic                     rd_ext,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [NB-1:0]            rd_be,
    input  logic [DATA_W-1:0]        rd_data,
    input  logic [NB-1:0]            rd_par,
    input  logic                     cfg_lvl_we,
    input  logic [pe_pkg::LVL_W-1:0] cfg_lvl,
    input  logic                     sts_clr,
    output logic                     term_ok,
    output logic                     bus_err,
    output logic                     irq_req,
    output logic [pe_pkg::LVL_W-1:0] irq_lvl,
    output logic                     err_valid,
    output logic                     err_ovf,
    output logic [ADDR_W-1:0]        err_addr
);
    logic [NB-1:0] bad_bytes;
    logic          par_err;
    logic          loc_pend;

    pe_byte_check #(.DATA_W(DATA_W)) u_chk (
        .data(rd_data), .par(rd_par), .be(rd_be),
        .bad(bad_bytes), .any_bad(par_err)
    );

    pe_resp u_resp (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ext(rd_ext),
        .par_err(par_err), .term_ok(term_ok), .bus_err(bus_err)
    );

    pe_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ext(rd_ext),
        .rd_addr(rd_addr), .par_err(par_err), .sts_clr(sts_clr),
        .err_valid(err_valid), .err_ovf(err_ovf), .err_addr(err_addr),
        .loc_pend(loc_pend)
    );

    pe_irq u_irq (
        .clk(clk), .rst_n(rst_n), .cfg_lvl_we(cfg_lvl_we), .cfg_lvl(cfg_lvl),
        .loc_pend(loc_pend), .irq_req(irq_req), .irq_lvl(irq_lvl)
    );

    AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ext && ((rd_be & (rd_par ^ {
            ^rd_data[31:24], ^rd_data[23:16], ^rd_data[15:8], ^rd_data[7:0]})) == '0))
        |=> !bus_err);                                                 // R2
endmodule

// File: tb/pe_report_unit_tb_top.sv
`timescale 1ns/1ps
module pe_report_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0, rd_ext = 1'b0;
    logic [31:0] rd_addr = '0, rd_data = '0;
    logic [3:0]  rd_be = '0, rd_par = '0;
    logic        cfg_lvl_we = 1'b0, sts_clr = 1'b0;
    logic [2:0]  cfg_lvl = '0;
    logic        term_ok, bus_err, irq_req, err_valid, err_ovf;
    logic [2:0]  irq_lvl;
    logic [31:0] err_addr;

    int checks = 0, failures = 0;
    string cur_req = "R10";

    // reference model state
    bit m_term, m_berr, m_valid, m_ovf, m_pend;
    int unsigned m_addr, m_lvl;

    always #2 clk = ~clk;

    pe_report_unit dut_i (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ext(rd_ext),
        .rd_addr(rd_addr), .rd_be(rd_be), .rd_data(rd_data), .rd_par(rd_par),
        .cfg_lvl_we(cfg_lvl_we), .cfg_lvl(cfg_lvl), .sts_clr(sts_clr),
        .term_ok(term_ok), .bus_err(bus_err), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .err_valid(err_valid), .err_ovf(err_ovf), .err_addr(err_addr)
    );

    function automatic bit model_err();
        bit e = 0;
        for (int i = 0; i < 4; i++) begin
            int ones = 0;
            for (int k = 0; k < 8; k++) ones += rd_data[8*i+k];
            ones += rd_par[i];
            if (rd_be[i] && (ones % 2 == 1)) e = 1;
        end
        return e;
    endfunction

    task automatic model_step();
        bit hit;
        if (!rst_n) begin
            m_term = 0; m_berr = 0; m_valid = 0; m_ovf = 0; m_pend = 0;
            m_addr = 0; m_lvl = 0;
            return;
        end
        hit = rd_valid && model_err();
        m_berr = hit && rd_ext;
        m_term = rd_valid && !m_berr;
        if (sts_clr) begin
            m_valid = hit; m_ovf = 0; m_pend = hit && !rd_ext;
            if (hit) m_addr = rd_addr;
        end else if (hit) begin
            if (!m_valid) begin m_valid = 1; m_addr = rd_addr; end
            else m_ovf = 1;
            if (!rd_ext) m_pend = 1;
        end
        if (cfg_lvl_we) m_lvl = cfg_lvl;
    endtask

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", tag, cur_req, act, exp);
        end
    endtask

    task automatic compare();
        bit irq_e = m_pend && (m_lvl != 0);
        chk("R3 term_ok/R4", term_ok, m_term);
        chk("R3 bus_err", bus_err, m_berr);
        chk("R5 irq_req", irq_req, irq_e);
        chk("R6 irq_lvl", irq_lvl, irq_e ? m_lvl : 0);
        chk("R7 err_valid", err_valid, m_valid);
        chk("R8 err_ovf", err_ovf, m_ovf);
        chk("R7 err_addr", err_addr, m_addr);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        rd_valid = 0; sts_clr = 0; cfg_lvl_we = 0;
    endtask

    // Drives one read with the bytes in flip given wrong parity.
    task automatic rd(bit ext, int unsigned addr, bit [3:0] be, bit [3:0] flip);
        rd_valid = 1; rd_ext = ext; rd_addr = addr; rd_be = be;
        rd_data = addr * 32'h9E37_79B1 + 32'h1357;
        for (int i = 0; i < 4; i++) rd_par[i] = (^rd_data[8*i +: 8]) ^ flip[i];
    endtask

    task automatic set_lvl(int unsigned l);
        cfg_lvl_we = 1; cfg_lvl = l[2:0];
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        cur_req = "R10";
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        chk("R10 reset irq_lvl", irq_lvl, 0);

        cur_req = "R1";
        rd(0, 32'h100, 4'hF, 4'h0); cyc();
        rd(1, 32'h104, 4'hF, 4'h0); cyc();
        cur_req = "R6";                       // level 0: pending but no request
        rd(0, 32'h200, 4'hF, 4'h4); cyc();
        cyc();
        cur_req = "R5";
        set_lvl(5); cyc();
        cyc();
        cur_req = "R8";
        rd(0, 32'h300, 4'hF, 4'h1); cyc();
        rd(1, 32'h304, 4'hF, 4'h8); cyc();
        chk("R8 held address", err_addr, 32'h200);
        cur_req = "R9";
        sts_clr = 1; cyc();
        sts_clr = 1; rd(1, 32'h400, 4'hF, 4'h2); cyc();
        chk("R9 same-cycle capture", err_addr, 32'h400);
        sts_clr = 1; cyc();
        cur_req = "R2";
        rd(1, 32'h500, 4'h3, 4'hC); cyc();
        chk("R2 disabled bytes ignored", err_valid, 0);
        rd(0, 32'h504, 4'h6, 4'h9); cyc();
        cur_req = "R4";
        rd(0, 32'h600, 4'h1, 4'h1); cyc();
        set_lvl(0); cyc();
        set_lvl(7); cyc();
        sts_clr = 1; cyc();

        cur_req = "R1";
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 2) != 0)
                rd($urandom_range(0, 1), $urandom, 4'($urandom),
                   ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0);
            if ($urandom_range(0, 15) == 0) sts_clr = 1;
            if ($urandom_range(0, 31) == 0) set_lvl($urandom_range(0, 7));
            cyc();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule